// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit holds the event flags of a bus-master serial controller, together with the interrupt enable mask and two DMA enables. A transfer engine raises flags through one-cycle set pulses. Software reaches the unit through a single-cycle register port. Through that port it reads the flags, clears selected ones by writing ones, and reads a vector that pops the pending enabled source with the lowest index. Three lines leave the block: one interrupt line, and one DMA request each for the receive and transmit directions.

A synthesis parameter selects between two variants. The older variant has a five-bit mask and supports the popping vector read, but its status register cannot be written. The newer variant has a six-bit mask, supports write-one-to-clear and supports a test-register trigger that forces the low six flags on. The bus-busy indication is not stored. It arrives on an input and is inserted into status reads only.

Top module: `irq_status_unit`

Register addresses: 0 enable mask, 1 status, 2 vector, 3 DMA configuration, 4 test trigger. Any other address reads 0 and ignores writes.

## Requirements
- R1: After reset, all flags, the mask and the DMA enables are zero and every output is low. From then on, `irq` is high exactly when the stored status AND the mask is nonzero.
- R2: `rx_dma_req` equals status bit 3 (receive ready) while DMA configuration bit 15 is set, and `tx_dma_req` equals status bit 4 (transmit ready) while DMA configuration bit 7 is set. Both ignore the mask.
- R3: A DMA configuration write keeps only bits 15 and 7, which read back at those positions. Writing bit 15 as 1 clears mask bit 3, and writing bit 7 as 1 clears mask bit 4.
- R4: In the older variant, a read of the vector register returns (index + 1) of the lowest set bit of status AND mask, and clears that status bit. When no such bit is set it returns 0 and changes nothing. In the newer variant the vector register reads 0 and has no effect.
- R5: In the newer variant, a status write clears only those bits that are set in both the written value and 0x0027, so the ready flags at bits 3 and 4 survive. In the older variant, status writes are ignored.
- R6: The mask keeps bits 5:0 of a write in the newer variant and bits 4:0 in the older variant. Other bits read as 0.
- R7: A status read returns the stored flags with bit 12 replaced by the `bus_busy` input. A set pulse on bit 12 is never stored.
- R8: In the newer variant, a test-register write with bit 11 set turns on status bits 5:0. In the older variant it has no effect.
- R9: A set pulse on a flag wins over a same-cycle clear of that flag, whether the clear comes from a status write or from a vector read.
- R10: Read data appears on `reg_rdata` with `reg_rvalid` high in the cycle after a read access. `reg_rvalid` stays low after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_pulse | input | 16 | One-cycle flag set requests from the transfer engine |
| bus_busy | input | 1 | Bus-busy indication, shown at status bit 12 |
| reg_valid | input | 1 | Register access in this cycle |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| reg_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
Every result is due one clock edge after its stimulus. Read data, flag updates, mask and enable changes are all captured by the edge that follows the access or pulse. The three request lines are decoded without registers from that updated state, so they are valid in the same cycle. The bench applies each access or pulse at a falling edge and samples at the next falling edge, which lies half a period after the capturing rising edge. Two instances, one per variant, share the same stimulus, so every check compares both variants against their own expected values at the same point in time.

// File: rtl/isu_pkg.sv
package isu_pkg;
    localparam int DW      = 16;   // register data width
    localparam int AW      = 3;    // register address width
    localparam int MW      = 6;    // widest mask
    localparam int VW      = $clog2(MW + 1);

    localparam int BUSY_BIT   = 12;
    localparam int RXRDY_BIT  = 3;
    localparam int TXRDY_BIT  = 4;
    localparam int RXDMA_BIT  = 15;
    localparam int TXDMA_BIT  = 7;
    localparam int FORCE_BIT  = 11;

    localparam logic [DW-1:0] W1C_ALLOWED = 16'h0027;
    localparam logic [DW-1:0] STORE_MASK  = ~(16'h1 << BUSY_BIT);

    typedef enum logic [AW-1:0] {
        A_ENABLE = 3'd0,
        A_STATUS = 3'd1,
        A_VECTOR = 3'd2,
        A_DMACFG = 3'd3,
        A_TEST   = 3'd4
    } isu_addr_e;
endpackage

// File: rtl/isu_pick.sv
module isu_pick
    import isu_pkg::*;
#(
    parameter int W = MW
) (
    input  logic [W-1:0]               pend,
    output logic                       hit,
    output logic [W-1:0]               sel,
    output logic [$clog2(W+1)-1:0]     code
);
    localparam int CW = $clog2(W + 1);

    always_comb begin
        hit  = 1'b0;
        sel  = '0;
        code = '0;
        // scan downwards so the lowest index is assigned last and wins
        for (int i = W - 1; i >= 0; i--) begin
            if (pend[i]) begin
                hit    = 1'b1;
                sel    = '0;
                sel[i] = 1'b1;
                code   = CW'(i + 1);
            end
        end
    end

    always_comb begin
        a_r4_sel_onehot: assert ($onehot0(sel));
        a_r4_sel_pending: assert ((sel & ~pend) == '0);
    end
endmodule

// File: rtl/isu_enables.sv
module isu_enables
    import isu_pkg::*;
#(
    parameter bit NEW_VARIANT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_mask,
    input  logic [MW-1:0] mask_wdata,
    input  logic          wr_dma,
    input  logic          dma_rx_wbit,
    input  logic          dma_tx_wbit,
    output logic [MW-1:0] mask_q,
    output logic          rx_en_q,
    output logic          tx_en_q
);
    localparam logic [MW-1:0] MASK_KEEP = NEW_VARIANT ? 6'h3f : 6'h1f;

    typedef struct packed {
        logic [MW-1:0] mask;
        logic          rx_en;
        logic          tx_en;
    } en_t;

    en_t en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr_mask) begin
            en_d.mask = mask_wdata & MASK_KEEP;
        end
        if (wr_dma) begin
            en_d.rx_en = dma_rx_wbit;
            en_d.tx_en = dma_tx_wbit;
            if (dma_rx_wbit) en_d.mask[RXRDY_BIT] = 1'b0;
            if (dma_tx_wbit) en_d.mask[TXRDY_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign mask_q  = en_q.mask;
    assign rx_en_q = en_q.rx_en;
    assign tx_en_q = en_q.tx_en;

    a_r3_rx_dma_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dma && dma_rx_wbit) |=> !mask_q[RXRDY_BIT]);
    a_r3_tx_dma_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dma && dma_tx_wbit) |=> !mask_q[TXRDY_BIT]);
    a_r3_dma_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dma |=> ($stable(rx_en_q) && $stable(tx_en_q)));
endmodule

// File: rtl/isu_flags.sv
module isu_flags
    import isu_pkg::*;
#(
    parameter bit NEW_VARIANT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_pulse,
    input  logic          w1c_en,
    input  logic [DW-1:0] w1c_data,
    input  logic [MW-1:0] vec_clr,
    input  logic          force_en,
    output logic [DW-1:0] stat_q
);
    typedef struct packed {
        logic [DW-1:0] stat;
    } fl_t;

    fl_t fl_d, fl_q;
    logic [DW-1:0] clr;

    always_comb begin
        clr = {{(DW-MW){1'b0}}, vec_clr};
        if (NEW_VARIANT && w1c_en) begin
            clr = clr | (w1c_data & W1C_ALLOWED);
        end
        fl_d.stat = fl_q.stat & ~clr;
        if (NEW_VARIANT && force_en) begin
            fl_d.stat[MW-1:0] = '1;
        end
        // set requests are applied last so they win over any clear
        fl_d.stat = (fl_d.stat | set_pulse) & STORE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign stat_q = fl_q.stat;

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_pulse & STORE_MASK)) |=>
            ((stat_q & $past(set_pulse & STORE_MASK)) == $past(set_pulse & STORE_MASK)));
    a_r5_ready_survives_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_en && vec_clr == '0) |=>
            ((stat_q[TXRDY_BIT:RXRDY_BIT] & $past(stat_q[TXRDY_BIT:RXRDY_BIT]))
             == $past(stat_q[TXRDY_BIT:RXRDY_BIT])));
    a_r7_busy_never_stored: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse[BUSY_BIT] |=> !stat_q[BUSY_BIT]);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import isu_pkg::*;
#(
    parameter bit NEW_VARIANT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   set_pulse,
    input  logic          bus_busy,
    input  logic          reg_valid,
    input  logic          reg_write,
    input  logic [2:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    output logic          reg_rvalid,
    output logic          irq,
    output logic          rx_dma_req,
    output logic          tx_dma_req
);
    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          rvalid;
    } rd_t;

    rd_t rd_d, rd_q;

    logic          wr_fire, rd_fire, vec_fire;
    logic [DW-1:0] stat_q;
    logic [MW-1:0] mask_q;
    logic          rx_en_q, tx_en_q;
    logic          pick_hit;
    logic [MW-1:0] pick_sel;
    logic [VW-1:0] pick_code;
    logic [MW-1:0] vec_clr;

    assign wr_fire  = reg_valid && reg_write;
    assign rd_fire  = reg_valid && !reg_write;
    assign vec_fire = rd_fire && (reg_addr == A_VECTOR) && !NEW_VARIANT;
    assign vec_clr  = vec_fire ? pick_sel : '0;

    isu_enables #(.NEW_VARIANT(NEW_VARIANT)) u_en (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_mask     (wr_fire && reg_addr == A_ENABLE),
        .mask_wdata  (reg_wdata[MW-1:0]),
        .wr_dma      (wr_fire && reg_addr == A_DMACFG),
        .dma_rx_wbit (reg_wdata[RXDMA_BIT]),
        .dma_tx_wbit (reg_wdata[TXDMA_BIT]),
        .mask_q      (mask_q),
        .rx_en_q     (rx_en_q),
        .tx_en_q     (tx_en_q)
    );

    isu_flags #(.NEW_VARIANT(NEW_VARIANT)) u_fl (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (set_pulse),
        .w1c_en    (wr_fire && reg_addr == A_STATUS),
        .w1c_data  (reg_wdata),
        .vec_clr   (vec_clr),
        .force_en  (wr_fire && reg_addr == A_TEST && reg_wdata[FORCE_BIT]),
        .stat_q    (stat_q)
    );

    isu_pick #(.W(MW)) u_pick (
        .pend (stat_q[MW-1:0] & mask_q),
        .hit  (pick_hit),
        .sel  (pick_sel),
        .code (pick_code)
    );

    always_comb begin
        rd_d        = '0;
        rd_d.rvalid = rd_fire;
        if (rd_fire) begin
            unique case (reg_addr)
                A_ENABLE: rd_d.rdata = {{(DW-MW){1'b0}}, mask_q};
                A_STATUS: begin
                    rd_d.rdata           = stat_q;
                    rd_d.rdata[BUSY_BIT] = bus_busy;
                end
                A_VECTOR: rd_d.rdata = NEW_VARIANT ? '0 : {{(DW-VW){1'b0}}, pick_code};
                A_DMACFG: begin
                    rd_d.rdata[RXDMA_BIT] = rx_en_q;
                    rd_d.rdata[TXDMA_BIT] = tx_en_q;
                end
                default:  rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata  = rd_q.rdata;
    assign reg_rvalid = rd_q.rvalid;
    assign irq        = |(stat_q[MW-1:0] & mask_q);
    assign rx_dma_req = rx_en_q && stat_q[RXRDY_BIT];
    assign tx_dma_req = tx_en_q && stat_q[TXRDY_BIT];

    a_r4_vector_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fire && pick_hit && !(|(set_pulse[MW-1:0] & pick_sel))) |=>
            ((stat_q[MW-1:0] & $past(pick_sel)) == '0));
    a_r10_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write) |=> reg_rvalid);
    a_r10_no_rvalid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write) |=> !reg_rvalid);
    a_r2_dma_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en_q |-> !rx_dma_req) and (!tx_en_q |-> !tx_dma_req));
endmodule

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] set_pulse = '0;
    logic        bus_busy = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;

    logic [15:0] rdata0, rdata1;
    logic        rvalid0, rvalid1, irq0, irq1, rxd0, rxd1, txd0, txd1;
    logic [15:0] rd0, rd1;
    logic        rv0, rv1;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_status_unit #(.NEW_VARIANT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .bus_busy(bus_busy),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata0), .reg_rvalid(rvalid0),
        .irq(irq0), .rx_dma_req(rxd0), .tx_dma_req(txd0));

    irq_status_unit #(.NEW_VARIANT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .bus_busy(bus_busy),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata1), .reg_rvalid(rvalid1),
        .irq(irq1), .rx_dma_req(rxd1), .tx_dma_req(txd1));

    localparam logic [2:0] AD_EN = 3'd0, AD_ST = 3'd1, AD_VEC = 3'd2,
                           AD_DMA = 3'd3, AD_TST = 3'd4;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: optional access plus set pulses; results sampled one edge later
    task automatic cyc(input logic v, input logic w, input logic [2:0] a,
                       input logic [15:0] d, input logic [15:0] p);
        @(negedge clk);
        reg_valid = v; reg_write = w; reg_addr = a; reg_wdata = d; set_pulse = p;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; set_pulse = '0;
        rd0 = rdata0; rd1 = rdata1; rv0 = rvalid0; rv1 = rvalid1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cyc(1'b1, 1'b1, a, d, 16'h0);
    endtask
    task automatic rd(input logic [2:0] a);
        cyc(1'b1, 1'b0, a, 16'h0, 16'h0);
    endtask
    task automatic pulse(input logic [15:0] p);
        cyc(1'b0, 1'b0, 3'd0, 16'h0, p);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; bus_busy = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state;
        do_reset();
        chk("R1 reset irq new", {15'b0, irq0}, 16'h0);
        chk("R1 reset irq old", {15'b0, irq1}, 16'h0);
        chk("R1 reset dma", {12'b0, rxd0, txd0, rxd1, txd1}, 16'h0);
        rd(AD_ST);
        chk("R1 reset status", rd0, 16'h0);
        rd(AD_EN);
        chk("R1 reset mask", rd1, 16'h0);
    endtask

    task automatic t_busy_and_rvalid;
        do_reset();
        bus_busy = 1'b1;
        rd(AD_ST);
        chk("R7 busy in status new", rd0, 16'h1000);
        chk("R7 busy in status old", rd1, 16'h1000);
        chk("R10 rvalid after read", {14'b0, rv0, rv1}, 16'h3);
        bus_busy = 1'b0;
        pulse(16'h1000);
        rd(AD_ST);
        chk("R7 bit12 not stored", rd0, 16'h0);
        wr(AD_EN, 16'h0001);
        chk("R10 no rvalid after write", {14'b0, rv0, rv1}, 16'h0);
    endtask

    task automatic t_mask_irq;
        do_reset();
        wr(AD_EN, 16'hffff);
        rd(AD_EN);
        chk("R6 mask width new", rd0, 16'h003f);
        chk("R6 mask width old", rd1, 16'h001f);
        pulse(16'h0020);
        chk("R1 irq bit5 new", {15'b0, irq0}, 16'h1);
        chk("R6 irq bit5 old masked", {15'b0, irq1}, 16'h0);
        wr(AD_ST, 16'h0020);
        chk("R1 irq drops after clear", {15'b0, irq0}, 16'h0);
        rd(AD_ST);
        chk("R5 w1c new", rd0, 16'h0000);
        chk("R5 status write ignored old", rd1, 16'h0020);
    endtask

    task automatic t_w1c_pattern;
        do_reset();
        pulse(16'h043f);
        wr(AD_ST, 16'hffff);
        rd(AD_ST);
        chk("R5 only 0x27 cleared new", rd0, 16'h0418);
        chk("R5 old unchanged", rd1, 16'h043f);
    endtask

    task automatic t_dma;
        do_reset();
        pulse(16'h0018);
        wr(AD_DMA, 16'h8080);
        chk("R2 both dma on new", {14'b0, rxd0, txd0}, 16'h3);
        chk("R2 both dma on old", {14'b0, rxd1, txd1}, 16'h3);
        chk("R2 dma ignores mask irq", {14'b0, irq0, irq1}, 16'h0);
        wr(AD_DMA, 16'h0080);
        chk("R2 rx off tx on", {14'b0, rxd0, txd0}, 16'h1);
        wr(AD_DMA, 16'h0000);
        chk("R2 both off", {14'b0, rxd0, txd0}, 16'h0);
        wr(AD_EN, 16'h003f);
        wr(AD_DMA, 16'hffff);
        rd(AD_DMA);
        chk("R3 dma cfg keeps 15 and 7", rd0, 16'h8080);
        rd(AD_EN);
        chk("R3 mask cleared new", rd0, 16'h0027);
        chk("R3 mask cleared old", rd1, 16'h0007);
    endtask

    task automatic t_vector;
        do_reset();
        wr(AD_EN, 16'h003f);
        pulse(16'h0016);
        rd(AD_VEC);
        chk("R4 vector first old", rd1, 16'd2);
        chk("R4 vector new reads zero", rd0, 16'd0);
        rd(AD_VEC);
        chk("R4 vector second old", rd1, 16'd3);
        rd(AD_VEC);
        chk("R4 vector third old", rd1, 16'd5);
        chk("R4 irq low after pops", {15'b0, irq1}, 16'h0);
        rd(AD_VEC);
        chk("R4 vector empty old", rd1, 16'd0);
        rd(AD_ST);
        chk("R4 new status untouched", rd0, 16'h0016);
        chk("R4 old status emptied", rd1, 16'h0000);
        do_reset();
        wr(AD_EN, 16'h0004);
        pulse(16'h0006);
        rd(AD_VEC);
        chk("R4 vector skips masked", rd1, 16'd3);
        rd(AD_VEC);
        chk("R4 vector none enabled", rd1, 16'd0);
        rd(AD_ST);
        chk("R4 masked bit kept", rd1, 16'h0002);
    endtask

    task automatic t_force;
        do_reset();
        wr(AD_TST, 16'h0800);
        rd(AD_ST);
        chk("R8 force new", rd0, 16'h003f);
        chk("R8 force ignored old", rd1, 16'h0000);
        chk("R8 forced no irq without mask", {15'b0, irq0}, 16'h0);
    endtask

    task automatic t_set_wins;
        do_reset();
        wr(AD_EN, 16'h0001);
        pulse(16'h0001);
        cyc(1'b1, 1'b1, AD_ST, 16'h0001, 16'h0001);
        rd(AD_ST);
        chk("R9 set beats w1c new", rd0, 16'h0001);
        cyc(1'b1, 1'b0, AD_VEC, 16'h0000, 16'h0001);
        chk("R9 vector value old", rd1, 16'd1);
        rd(AD_ST);
        chk("R9 set beats vector clear old", rd1, 16'h0001);
        chk("R9 irq stays old", {15'b0, irq1}, 16'h1);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_busy_and_rvalid();
        t_mask_irq();
        t_w1c_pattern();
        t_dma();
        t_vector();
        t_force();
        t_set_wins();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule